// File: doc/BRIEF.md
# Sequenced Colour-Map Register Port

This block holds a colour map of 256 normal entries and 4 overlay entries. Each entry carries an 8-bit red, green and blue value. Software reaches the map through a 16-byte register window of 32-bit words, and every colour byte travels in the top byte of the word. One word loads an entry pointer. The data words then walk through the components of the addressed entry in the order red, green, blue. After blue the pointer steps to the next entry, so a host can stream a whole palette after a single pointer write. A second data word offset steers the same byte stream into the four overlay entries. The overlay entry is chosen by the low two bits of the pointer.

The walk through the components is a three-state machine: `PH_RED`, `PH_GREEN` and `PH_BLUE`. Three transitions exist:

- **load**: a pointer write forces `PH_RED` from any state.
- **advance**: a data access moves `PH_RED` to `PH_GREEN` and `PH_GREEN` to `PH_BLUE`.
- **wrap**: a data access in `PH_BLUE` returns to `PH_RED` and increments the pointer modulo 256.

Register reads advance the machine exactly as data writes do. The pixel pipeline reads any of the 260 entries through a separate registered lookup port. That port never disturbs the pointer or the state.

Top module: `palette_dac`

## Requirements
- R1: After reset, every entry reads 0 except entries 255, 256 and 258, which hold 0xFFFFFF. The pointer is 0 and the state is `PH_RED`.
- R2: A full-width write to byte offset 0 loads the pointer from data bits 31:24 and forces `PH_RED` (load).
- R3: A full-width write to byte offset 4 stores data bits 31:24 into the current component of the entry at the pointer, then steps `PH_RED`→`PH_GREEN`→`PH_BLUE` (advance). Bits 23:0 of the write data are not used.
- R4: A data access in `PH_BLUE` returns the state to `PH_RED` and increments the pointer modulo 256, so pointer 255 becomes 0 (wrap).
- R5: A full-width write to byte offset 12 behaves as R3 and R4, but it targets entry 256 + (pointer mod 4) and leaves the normal entries untouched.
- R6: A full-width read at any offset sets `reg_rvalid` for one cycle after the access. The cycle carries the current component of the entry at the pointer in bits 31:24 and zeros in bits 23:0. The read advances the state as in R3 and R4.
- R7: A full-width write to byte offset 8, or to any offset other than 0, 4 or 12, changes no entry, no pointer and no state.
- R8: An access whose byte enables are not all ones is dropped entirely: no store, no pointer or state change, and no `reg_rvalid`.
- R9: `lut_rgb` shows the entry at `lut_addr` one clock after the address is sampled, packed as red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Addresses 260 and above return 0.
- R10: With `reg_sel` low, the pointer and the state hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access strobe, one access per cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset inside the window |
| reg_be | input | 4 | Byte enables; only 4'hF is accepted |
| reg_wdata | input | 32 | Write data; colour or pointer in bits 31:24 |
| reg_rdata | output | 32 | Read data; component in bits 31:24 |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| lut_addr | input | 9 | Pixel lookup entry number |
| lut_rgb | output | 24 | Looked-up colour, registered |

## Verification
A wrong pointer or a state stuck in the wrong component appears at the lookup port one clock after the next data write lands in the wrong place. It also appears on `reg_rdata` one clock after the next read. The bench therefore follows every write burst with lookups of the target entry and of its neighbours. A missed wrap or a missed load shows up at the fourth write of a burst. The bench checks for that by writing one byte past each burst. A dropped partial or stray access is only visible through the following legal write. So each ignored access is followed by a write whose landing entry and component are checked.

// File: rtl/palette_dac_pkg.sv
`timescale 1ns/1ps
package palette_dac_pkg;
    // Encoding equals the byte lane inside a packed {R,G,B} word.
    typedef enum logic [1:0] {
        PH_BLUE  = 2'd0,
        PH_GREEN = 2'd1,
        PH_RED   = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        CMD_NONE       = 3'd0,
        CMD_SET_INDEX  = 3'd1,
        CMD_WR_NORMAL  = 3'd2,
        CMD_WR_OVERLAY = 3'd3,
        CMD_READ       = 3'd4
    } cmd_e;
endpackage

// File: rtl/palette_dac_decode.sv
`timescale 1ns/1ps
module palette_dac_decode
    import palette_dac_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int OFS_INDEX   = 0,
    parameter int OFS_NORMAL  = 4,
    parameter int OFS_OVERLAY = 12
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W/8-1:0] be,
    output cmd_e              cmd
);
    localparam int BE_W = DATA_W / 8;

    logic full_word;
    assign full_word = (be == {BE_W{1'b1}});

    always_comb begin
        cmd = CMD_NONE;
        if (sel && full_word) begin
            if (!we) begin
                cmd = CMD_READ;
            end else if (addr == ADDR_W'(OFS_INDEX)) begin
                cmd = CMD_SET_INDEX;
            end else if (addr == ADDR_W'(OFS_NORMAL)) begin
                cmd = CMD_WR_NORMAL;
            end else if (addr == ADDR_W'(OFS_OVERLAY)) begin
                cmd = CMD_WR_OVERLAY;
            end
        end
    end
endmodule

// File: rtl/palette_dac_seq.sv
`timescale 1ns/1ps
module palette_dac_seq
    import palette_dac_pkg::*;
#(
    parameter int N_NORMAL  = 256,
    parameter int N_OVERLAY = 4,
    parameter int COMP_W    = 8
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  cmd_e                                          cmd,
    input  logic [COMP_W-1:0]                             cmd_byte,
    output logic [$clog2(N_NORMAL)-1:0]                   idx_q,
    output phase_e                                        phase_q,
    output logic                                          acc_we,
    output logic                                          acc_rd,
    output logic [$clog2(N_NORMAL+N_OVERLAY)-1:0]         acc_entry,
    output phase_e                                        acc_comp
);
    localparam int IDX_W = $clog2(N_NORMAL);
    localparam int ENT_W = $clog2(N_NORMAL + N_OVERLAY);
    localparam int OVL_W = (N_OVERLAY > 1) ? $clog2(N_OVERLAY) : 1;

    phase_e             phase_d;
    logic [IDX_W-1:0]   idx_d;
    logic               data_access;

    assign data_access = (cmd == CMD_WR_NORMAL) || (cmd == CMD_WR_OVERLAY) ||
                         (cmd == CMD_READ);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RED;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    // Next state: load, advance, wrap
    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        if (cmd == CMD_SET_INDEX) begin
            phase_d = PH_RED;
            idx_d   = IDX_W'(cmd_byte);
        end else if (data_access) begin
            unique case (phase_q)
                PH_RED:   phase_d = PH_GREEN;
                PH_GREEN: phase_d = PH_BLUE;
                PH_BLUE: begin
                    phase_d = PH_RED;
                    idx_d   = idx_q + 1'b1;
                end
                default:  phase_d = PH_RED;
            endcase
        end
    end

    // Outputs
    always_comb begin
        acc_we    = (cmd == CMD_WR_NORMAL) || (cmd == CMD_WR_OVERLAY);
        acc_rd    = (cmd == CMD_READ);
        acc_comp  = phase_q;
        if (cmd == CMD_WR_OVERLAY) begin
            acc_entry = ENT_W'(N_NORMAL) + ENT_W'(idx_q[OVL_W-1:0]);
        end else begin
            acc_entry = ENT_W'(idx_q);
        end
    end
endmodule

// File: rtl/palette_dac_store.sv
`timescale 1ns/1ps
module palette_dac_store
    import palette_dac_pkg::*;
#(
    parameter int N_NORMAL  = 256,
    parameter int N_OVERLAY = 4,
    parameter int COMP_W    = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      wr_en,
    input  logic                                      rd_en,
    input  logic [$clog2(N_NORMAL+N_OVERLAY)-1:0]     entry,
    input  phase_e                                    comp,
    input  logic [COMP_W-1:0]                         wr_byte,
    input  logic [$clog2(N_NORMAL+N_OVERLAY)-1:0]     lut_addr,
    output logic [COMP_W-1:0]                         rd_byte_q,
    output logic                                      rd_valid_q,
    output logic [3*COMP_W-1:0]                       lut_rgb_q
);
    localparam int N_ENT = N_NORMAL + N_OVERLAY;
    localparam int ENT_W = $clog2(N_ENT);
    localparam int RGB_W = 3 * COMP_W;

    logic [RGB_W-1:0] ent_q [N_ENT];

    function automatic logic [RGB_W-1:0] reset_value(input int e);
        if (e == N_NORMAL - 1 || e == N_NORMAL || e == N_NORMAL + 2)
            return {RGB_W{1'b1}};
        return '0;
    endfunction

    for (genvar e = 0; e < N_ENT; e++) begin : g_entry
        logic hit;
        assign hit = wr_en && (entry == ENT_W'(e));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[e] <= reset_value(e);
            end else if (hit) begin
                ent_q[e][int'(comp)*COMP_W +: COMP_W] <= wr_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_byte_q  <= '0;
            rd_valid_q <= 1'b0;
            lut_rgb_q  <= '0;
        end else begin
            rd_valid_q <= rd_en;
            if (rd_en) begin
                rd_byte_q <= ent_q[entry][int'(comp)*COMP_W +: COMP_W];
            end
            if (lut_addr < ENT_W'(N_ENT)) begin
                lut_rgb_q <= ent_q[lut_addr];
            end else begin
                lut_rgb_q <= '0;
            end
        end
    end
endmodule

// File: rtl/palette_dac.sv
`timescale 1ns/1ps
module palette_dac
    import palette_dac_pkg::*;
#(
    parameter int N_NORMAL    = 256,
    parameter int N_OVERLAY   = 4,
    parameter int COMP_W      = 8,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int OFS_INDEX   = 0,
    parameter int OFS_NORMAL  = 4,
    parameter int OFS_OVERLAY = 12
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  reg_sel,
    input  logic                                  reg_we,
    input  logic [ADDR_W-1:0]                     reg_addr,
    input  logic [DATA_W/8-1:0]                   reg_be,
    input  logic [DATA_W-1:0]                     reg_wdata,
    output logic [DATA_W-1:0]                     reg_rdata,
    output logic                                  reg_rvalid,
    input  logic [$clog2(N_NORMAL+N_OVERLAY)-1:0] lut_addr,
    output logic [3*COMP_W-1:0]                   lut_rgb
);
    localparam int IDX_W = $clog2(N_NORMAL);
    localparam int ENT_W = $clog2(N_NORMAL + N_OVERLAY);

    cmd_e               cmd;
    logic [IDX_W-1:0]   seq_idx;
    phase_e             seq_phase;
    logic               acc_we;
    logic               acc_rd;
    logic [ENT_W-1:0]   acc_entry;
    phase_e             acc_comp;
    logic [COMP_W-1:0]  rd_byte;
    logic [COMP_W-1:0]  top_byte;

    assign top_byte = reg_wdata[DATA_W-1 -: COMP_W];

    palette_dac_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_INDEX(OFS_INDEX),
        .OFS_NORMAL(OFS_NORMAL), .OFS_OVERLAY(OFS_OVERLAY)
    ) decode_i (
        .sel(reg_sel), .we(reg_we), .addr(reg_addr), .be(reg_be), .cmd(cmd)
    );

    palette_dac_seq #(
        .N_NORMAL(N_NORMAL), .N_OVERLAY(N_OVERLAY), .COMP_W(COMP_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_byte(top_byte),
        .idx_q(seq_idx), .phase_q(seq_phase), .acc_we(acc_we), .acc_rd(acc_rd),
        .acc_entry(acc_entry), .acc_comp(acc_comp)
    );

    palette_dac_store #(
        .N_NORMAL(N_NORMAL), .N_OVERLAY(N_OVERLAY), .COMP_W(COMP_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(acc_we), .rd_en(acc_rd),
        .entry(acc_entry), .comp(acc_comp), .wr_byte(top_byte),
        .lut_addr(lut_addr), .rd_byte_q(rd_byte), .rd_valid_q(reg_rvalid),
        .lut_rgb_q(lut_rgb)
    );

    assign reg_rdata = {rd_byte, {(DATA_W-COMP_W){1'b0}}};
endmodule

// File: rtl/palette_dac_chk.sv
`timescale 1ns/1ps
module palette_dac_chk
    import palette_dac_pkg::*;
#(
    parameter int N_NORMAL    = 256,
    parameter int N_OVERLAY   = 4,
    parameter int COMP_W      = 8,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int OFS_INDEX   = 0,
    parameter int OFS_NORMAL  = 4,
    parameter int OFS_OVERLAY = 12
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  reg_sel,
    input logic                                  reg_we,
    input logic [ADDR_W-1:0]                     reg_addr,
    input logic [DATA_W/8-1:0]                   reg_be,
    input logic [DATA_W-1:0]                     reg_wdata,
    input logic [DATA_W-1:0]                     reg_rdata,
    input logic                                  reg_rvalid,
    input logic [$clog2(N_NORMAL+N_OVERLAY)-1:0] lut_addr,
    input logic [3*COMP_W-1:0]                   lut_rgb,
    input logic [$clog2(N_NORMAL)-1:0]           idx_q,
    input phase_e                                phase_q
);
    localparam int IDX_W = $clog2(N_NORMAL);
    localparam int ENT_W = $clog2(N_NORMAL + N_OVERLAY);
    localparam int BE_W  = DATA_W / 8;

    logic full_acc;
    logic data_wr;
    assign full_acc = reg_sel && (reg_be == {BE_W{1'b1}});
    assign data_wr  = full_acc && reg_we &&
                      (reg_addr == ADDR_W'(OFS_NORMAL) || reg_addr == ADDR_W'(OFS_OVERLAY));

    // R2
    load_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_acc && reg_we && reg_addr == ADDR_W'(OFS_INDEX)) |=>
        (idx_q == IDX_W'($past(reg_wdata[DATA_W-1 -: COMP_W])) && phase_q == PH_RED));

    // R4
    blue_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && phase_q == PH_BLUE) |=>
        (idx_q == IDX_W'($past(idx_q) + 1'b1) && phase_q == PH_RED));

    // R6
    read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_acc && !reg_we) |=>
        (reg_rvalid && reg_rdata[DATA_W-COMP_W-1:0] == '0));

    // R8
    partial_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_be != {BE_W{1'b1}}) |=>
        ($stable(idx_q) && $stable(phase_q) && !reg_rvalid));

    // R9
    lut_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lut_addr >= ENT_W'(N_NORMAL + N_OVERLAY)) |=> (lut_rgb == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_sel) |=> ($stable(idx_q) && $stable(phase_q)));
endmodule

bind palette_dac palette_dac_chk #(
    .N_NORMAL(N_NORMAL), .N_OVERLAY(N_OVERLAY), .COMP_W(COMP_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .OFS_INDEX(OFS_INDEX), .OFS_NORMAL(OFS_NORMAL),
    .OFS_OVERLAY(OFS_OVERLAY)
) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .lut_addr(lut_addr),
    .lut_rgb(lut_rgb), .idx_q(seq_idx), .phase_q(seq_phase)
);

// File: tb/palette_dac_tb_top.sv
`timescale 1ns/1ps
module palette_dac_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [8:0]  lut_addr = '0;
    logic [23:0] lut_rgb;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    palette_dac dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .lut_addr(lut_addr), .lut_rgb(lut_rgb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [3:0] be,
                          output logic [31:0] d, output logic v);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a; reg_be = be;
        @(negedge clk);
        reg_sel = 1'b0;
        d = reg_rdata; v = reg_rvalid;
    endtask

    task automatic lut_expect(input string req, input int a, input logic [23:0] exp);
        @(negedge clk);
        lut_addr = 9'(a);
        @(negedge clk);
        check(req, {8'h0, lut_rgb}, {8'h0, exp});
    endtask

    task automatic t_reset;
        lut_expect("R1 entry0", 0, 24'h000000);
        lut_expect("R1 entry254", 254, 24'h000000);
        lut_expect("R1 entry255", 255, 24'hFFFFFF);
        lut_expect("R1 entry256", 256, 24'hFFFFFF);
        lut_expect("R1 entry257", 257, 24'h000000);
        lut_expect("R1 entry258", 258, 24'hFFFFFF);
        lut_expect("R1 entry259", 259, 24'h000000);
    endtask

    task automatic t_read_wrap;
        logic [31:0] d; logic v;
        bus_wr(4'd0, 32'hFF00_0000, 4'hF);
        for (int k = 0; k < 3; k++) begin
            bus_rd(4'd4, 4'hF, d, v);
            check("R6 read valid", {31'h0, v}, 32'h1);
            check("R6 read white component", d, 32'hFF00_0000);
        end
        bus_rd(4'd8, 4'hF, d, v);
        check("R4 read after wrap hits entry0", d, 32'h0000_0000);
        check("R6 read valid any offset", {31'h0, v}, 32'h1);
    endtask

    task automatic t_write_seq;
        bus_wr(4'd0, 32'h0500_0000, 4'hF);
        bus_wr(4'd4, 32'h1112_3456, 4'hF);
        bus_wr(4'd4, 32'h22AB_CDEF, 4'hF);
        bus_wr(4'd4, 32'h3300_0001, 4'hF);
        lut_expect("R3 entry5 RGB", 5, 24'h112233);
        bus_wr(4'd4, 32'h4400_0000, 4'hF);
        lut_expect("R4 next entry red", 6, 24'h440000);
        lut_expect("R3 entry4 untouched", 4, 24'h000000);
    endtask

    task automatic t_index_wrap;
        bus_wr(4'd0, 32'hFF00_0000, 4'hF);
        bus_wr(4'd4, 32'hAA00_0000, 4'hF);
        bus_wr(4'd4, 32'hBB00_0000, 4'hF);
        bus_wr(4'd4, 32'hCC00_0000, 4'hF);
        bus_wr(4'd4, 32'h0100_0000, 4'hF);
        lut_expect("R4 entry255", 255, 24'hAABBCC);
        lut_expect("R4 wrap to entry0", 0, 24'h010000);
    endtask

    task automatic t_overlay;
        bus_wr(4'd0, 32'h0600_0000, 4'hF);
        bus_wr(4'd12, 32'h1000_0000, 4'hF);
        bus_wr(4'd12, 32'h2000_0000, 4'hF);
        bus_wr(4'd12, 32'h3000_0000, 4'hF);
        bus_wr(4'd12, 32'h5500_0000, 4'hF);
        lut_expect("R5 overlay 258", 258, 24'h102030);
        lut_expect("R5 overlay 259 after step", 259, 24'h55FFFF & 24'hFF0000);
        lut_expect("R5 normal entry6 untouched", 6, 24'h440000);
        lut_expect("R5 normal entry7 untouched", 7, 24'h000000);
    endtask

    task automatic t_read_back;
        logic [31:0] d; logic v;
        bus_wr(4'd0, 32'h0500_0000, 4'hF);
        bus_rd(4'd4, 4'hF, d, v);
        check("R6 red", d, 32'h1100_0000);
        bus_rd(4'd4, 4'hF, d, v);
        check("R6 green", d, 32'h2200_0000);
        bus_rd(4'd4, 4'hF, d, v);
        check("R6 blue", d, 32'h3300_0000);
        bus_rd(4'd4, 4'hF, d, v);
        check("R6 read wrap to entry6", d, 32'h4400_0000);
    endtask

    task automatic t_reload;
        bus_wr(4'd0, 32'h0900_0000, 4'hF);
        bus_wr(4'd4, 32'h9900_0000, 4'hF);
        bus_wr(4'd0, 32'h0900_0000, 4'hF);
        bus_wr(4'd4, 32'h7700_0000, 4'hF);
        lut_expect("R2 reload resets to red", 9, 24'h770000);
    endtask

    task automatic t_ignored;
        logic [31:0] d; logic v;
        bus_wr(4'd0, 32'h0A00_0000, 4'hF);
        bus_wr(4'd8, 32'hEE00_0000, 4'hF);
        bus_wr(4'd6, 32'hEF00_0000, 4'hF);
        bus_wr(4'd4, 32'hDD00_0000, 4'h7);
        bus_wr(4'd0, 32'h2000_0000, 4'h3);
        bus_rd(4'd4, 4'hE, d, v);
        check("R8 partial read no valid", {31'h0, v}, 32'h0);
        lut_expect("R7 entry10 unchanged", 10, 24'h000000);
        bus_wr(4'd4, 32'h1200_0000, 4'hF);
        lut_expect("R7 R8 state kept red on entry10", 10, 24'h120000);
        lut_expect("R8 entry32 unchanged", 32, 24'h000000);
    endtask

    task automatic t_lookup;
        @(negedge clk);
        lut_addr = 9'd255;
        @(negedge clk);
        check("R9 latency value", {8'h0, lut_rgb}, 32'h00AABBCC);
        lut_addr = 9'd0;
        #1;
        check("R9 output registered", {8'h0, lut_rgb}, 32'h00AABBCC);
        lut_expect("R9 out of range 300", 300, 24'h000000);
        lut_expect("R9 out of range 511", 511, 24'h000000);
        lut_expect("R9 back in range", 258, 24'h102030);
    endtask

    initial begin
        #(4 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_wrap();
        t_write_seq();
        t_index_wrap();
        t_overlay();
        t_read_back();
        t_reload();
        t_ignored();
        t_lookup();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule